// File: doc/BRIEF.md
# Paged GPIO Register Bank

This block is the byte-wide register front end of a 48-line general-purpose I/O bank built from six 8-bit ports. Each line is open-drain: a set data bit makes the pin sink current and pull low, and a clear bit releases it so that an external pull-up brings it high. A port read returns the inverted, synchronized pin level. A released pin that is held high therefore reads 0, and a pin that is low for any reason reads 1.

The bank decodes a 16-byte window. The port data bytes, a pending-summary byte and a page/lock byte are visible on every page. Three further offsets show one of three 24-bit extended registers, chosen by the page field: edge polarity, edge enable and captured-event identity. These registers go straight to a neighbouring edge-detect unit. That unit ORs new events into the identity register and can clear it as a whole.

Top module: `pgpio_bank`

## Requirements
- R1: After reset all port data bits, the page/lock byte and the polarity, enable and identity registers are zero, so every pin is released (`pin_sink` all zero).
- R2: Writing a port data byte at offset 0x00+k (k = 0..5) sets `pin_sink[8k+7:8k]` to that byte from the next clock edge; a 1 sinks the pin low and a 0 releases it.
- R3: A read of offset 0x00+k returns the bitwise inverse of `pin_level[8k+7:8k]` after a two-flop synchronizer, so a level change becomes visible to a read issued two cycles later and not to a read issued in the same cycle.
- R4: Offsets 0x00 to 0x05 read and write the port data the same way whatever page is selected.
- R5: Offset 0x07 is the page/lock byte and reads back what was written; bits 7:6 select the page (0 base, 1 polarity, 2 enable, 3 identity) and bit k (k = 0..5) locks port k.
- R6: While the lock bit of port k is set, writes to offset 0x00+k are ignored; reads of that port are unaffected.
- R7: On pages 1, 2 and 3, offset 0x08+b (b = 0..2) reads and writes bits 8b+7:8b of the polarity, enable or identity register respectively, and these registers appear on `edge_pol`, `edge_ena` and `edge_evt`.
- R8: On page 0, offsets 0x08 to 0x0A read 0x00 and writes there change nothing; offsets 0x0B to 0x0F always read 0x00.
- R9: `evt_set` ORs into the identity register each cycle; `evt_clr` clears it, with events set in the same cycle still recorded.
- R10: Offset 0x06 reads a summary where bit b (b = 0..2) is the OR of identity byte b, and bits 7:3 are 0.
- R11: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_level | input | 48 | Sampled pin levels |
| pin_sink | output | 48 | Open-drain pull-low enables |
| edge_pol | output | 24 | Polarity register to the edge-detect unit |
| edge_ena | output | 24 | Enable register to the edge-detect unit |
| edge_evt | output | 24 | Identity register to the edge-detect unit |
| evt_set | input | 24 | Event capture bits from the edge-detect unit |
| evt_clr | input | 1 | Clear of the identity register from the edge-detect unit |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are meaningful only when a strobe is high. They also assume that `evt_set` and `evt_clr` stay low unless the edge-detect unit is reporting. The lock and identity properties compare a register with its own value one cycle later, so they hold whatever the pin inputs do. The bench drives every strobe for exactly one cycle and changes pins and event inputs only at falling edges. It waits three cycles after each access, which gives the synchronizer time to settle before the next read. The one exception is a single read that is issued on purpose in the same cycle as a pin change.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EXT_BASE = 8;
  localparam logic [3:0]  OFS_PEND = 4'h6;
  localparam logic [3:0]  OFS_PAGE = 4'h7;

  typedef enum logic [1:0] {
    PG_BASE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_EVT  = 2'd3
  } page_e;
endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int unsigned WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/pgpio_port_regs.sv
module pgpio_port_regs
  import pgpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [NUM_PORTS-1:0]        port_sel,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic [NUM_PORTS-1:0]        lock,
  output logic [NUM_PORTS*BYTE_W-1:0] data_q
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              load;
    logic [BYTE_W-1:0] byte_d;
    logic [BYTE_W-1:0] byte_q;

    always_comb begin
      load   = wr_en && port_sel[p] && !lock[p];
      byte_d = load ? wdata : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign data_q[p*BYTE_W +: BYTE_W] = byte_q;

    assert_locked_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel[p] && lock[p]) |=> $stable(data_q[p*BYTE_W +: BYTE_W]));
  end
endmodule

// File: rtl/pgpio_ext_regs.sv
module pgpio_ext_regs
  import pgpio_pkg::*;
#(
  parameter int unsigned EXT_BYTES = 3,
  localparam int unsigned EXT_W    = EXT_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  page_e                page,
  input  logic [EXT_BYTES-1:0] byte_sel,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic [EXT_W-1:0]     evt_set,
  input  logic                 evt_clr,
  output logic [EXT_W-1:0]     pol_q,
  output logic [EXT_W-1:0]     ena_q,
  output logic [EXT_W-1:0]     evt_q
);
  logic [EXT_W-1:0] pol_d, ena_d, evt_d;

  for (genvar b = 0; b < EXT_BYTES; b++) begin : g_byte
    logic wr_pol, wr_ena, wr_evt;
    logic [BYTE_W-1:0] evt_base;

    always_comb begin
      wr_pol   = wr_en && byte_sel[b] && (page == PG_POL);
      wr_ena   = wr_en && byte_sel[b] && (page == PG_ENA);
      wr_evt   = wr_en && byte_sel[b] && (page == PG_EVT);
      evt_base = wr_evt ? wdata : evt_q[b*BYTE_W +: BYTE_W];
      pol_d[b*BYTE_W +: BYTE_W] = wr_pol ? wdata : pol_q[b*BYTE_W +: BYTE_W];
      ena_d[b*BYTE_W +: BYTE_W] = wr_ena ? wdata : ena_q[b*BYTE_W +: BYTE_W];
      evt_d[b*BYTE_W +: BYTE_W] = (evt_clr ? '0 : evt_base)
                                  | evt_set[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ena_q <= '0;
      evt_q <= '0;
    end else begin
      pol_q <= pol_d;
      ena_q <= ena_d;
      evt_q <= evt_d;
    end
  end

  assert_evt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && (evt_set == '0)) |=> (evt_q == '0));

  assert_evt_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  assert_base_page_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (page == PG_BASE) && !evt_clr && (evt_set == '0))
      |=> ($stable(pol_q) && $stable(ena_q) && $stable(evt_q)));
endmodule

// File: rtl/pgpio_bank.sv
module pgpio_bank
  import pgpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned EXT_BYTES = 3,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned LINES    = NUM_PORTS * BYTE_W,
  localparam int unsigned EXT_W    = EXT_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  pin_level,
  output logic [LINES-1:0]  pin_sink,
  output logic [EXT_W-1:0]  edge_pol,
  output logic [EXT_W-1:0]  edge_ena,
  output logic [EXT_W-1:0]  edge_evt,
  input  logic [EXT_W-1:0]  evt_set,
  input  logic              evt_clr
);
  logic [NUM_PORTS-1:0] port_sel;
  logic [EXT_BYTES-1:0] ext_sel;
  logic [BYTE_W-1:0]    ctl_q, ctl_d;
  logic [BYTE_W-1:0]    rdata_q, rdata_d;
  logic [LINES-1:0]     pin_sync;
  page_e                page;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) port_sel[p] = (bus_addr == ADDR_W'(p));
    for (int b = 0; b < EXT_BYTES; b++) ext_sel[b] = (bus_addr == ADDR_W'(EXT_BASE + b));
  end

  assign page = page_e'(ctl_q[BYTE_W-1 -: 2]);

  // page/lock byte
  always_comb ctl_d = (bus_wr && bus_addr == OFS_PAGE) ? bus_wdata : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  pgpio_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_level), .d_out(pin_sync)
  );

  pgpio_port_regs #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .port_sel(port_sel),
    .wdata(bus_wdata), .lock(ctl_q[NUM_PORTS-1:0]), .data_q(pin_sink)
  );

  pgpio_ext_regs #(.EXT_BYTES(EXT_BYTES)) u_ext (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .page(page), .byte_sel(ext_sel),
    .wdata(bus_wdata), .evt_set(evt_set), .evt_clr(evt_clr),
    .pol_q(edge_pol), .ena_q(edge_ena), .evt_q(edge_evt)
  );

  // read mux: selects are mutually exclusive
  always_comb begin
    rdata_d = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (port_sel[p]) rdata_d = ~pin_sync[p*BYTE_W +: BYTE_W];
    if (bus_addr == OFS_PEND)
      for (int b = 0; b < EXT_BYTES; b++) rdata_d[b] = |edge_evt[b*BYTE_W +: BYTE_W];
    if (bus_addr == OFS_PAGE) rdata_d = ctl_q;
    for (int b = 0; b < EXT_BYTES; b++) begin
      if (ext_sel[b]) begin
        unique case (page)
          PG_POL:  rdata_d = edge_pol[b*BYTE_W +: BYTE_W];
          PG_ENA:  rdata_d = edge_ena[b*BYTE_W +: BYTE_W];
          PG_EVT:  rdata_d = edge_evt[b*BYTE_W +: BYTE_W];
          default: rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= ADDR_W'(EXT_BASE + EXT_BYTES)) |=> (bus_rdata == '0));

  assert_base_page_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (ext_sel != '0) && page == PG_BASE) |=> (bus_rdata == '0));

  assert_pend_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_PEND) |=> ((bus_rdata >> EXT_BYTES) == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_page_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PAGE) |=> (ctl_q == $past(bus_wdata)));
endmodule

// File: tb/pgpio_bank_tb.sv
`timescale 1ns/1ps
module pgpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_level, pin_sink, ext_low;
  logic [23:0] edge_pol, edge_ena, edge_evt, evt_set;
  logic        evt_clr;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  // open-drain wire: low if the block sinks or an external device pulls low
  assign pin_level = ~pin_sink & ~ext_low;

  pgpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_level(pin_level), .pin_sink(pin_sink), .edge_pol(edge_pol),
    .edge_ena(edge_ena), .edge_evt(edge_evt), .evt_set(evt_set), .evt_clr(evt_clr)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h0, 8'hA5, 8'h00},  // R2 port 0
    {1'b0, 4'h0, 8'h00, 8'hA5},  // R2 readback through pin
    {1'b1, 4'h7, 8'h40, 8'h00},  // R5 page 1
    {1'b1, 4'h3, 8'h3C, 8'h00},  // R4 port on page 1
    {1'b0, 4'h3, 8'h00, 8'h3C},  // R4
    {1'b1, 4'h8, 8'h11, 8'h00},  // R7 polarity bytes
    {1'b1, 4'h9, 8'h22, 8'h00},
    {1'b1, 4'hA, 8'h33, 8'h00},
    {1'b0, 4'h8, 8'h00, 8'h11},  // R7
    {1'b0, 4'hA, 8'h00, 8'h33},  // R7
    {1'b1, 4'h7, 8'h80, 8'h00},  // R5 page 2
    {1'b1, 4'h9, 8'hF0, 8'h00},  // R7 enable byte 1
    {1'b0, 4'h9, 8'h00, 8'hF0},  // R7
    {1'b0, 4'h8, 8'h00, 8'h00},  // R7 enable byte 0 untouched
    {1'b1, 4'h7, 8'h01, 8'h00},  // R6 page 0, lock port 0
    {1'b1, 4'h0, 8'hFF, 8'h00},  // R6 write ignored
    {1'b0, 4'h0, 8'h00, 8'hA5},  // R6
    {1'b0, 4'h7, 8'h00, 8'h01},  // R5 readback
    {1'b1, 4'h8, 8'h77, 8'h00},  // R8 page 0 write
    {1'b0, 4'h8, 8'h00, 8'h00},  // R8 page 0 read
    {1'b0, 4'hC, 8'h00, 8'h00},  // R8 unmapped
    {1'b1, 4'h7, 8'h00, 8'h00},  // R6 unlock
    {1'b1, 4'h0, 8'h0F, 8'h00},
    {1'b0, 4'h0, 8'h00, 8'h0F}   // R6 write accepted after unlock
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_low = '0; evt_set = '0; evt_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sink", pin_sink, 48'h0);
    chk("R1 exports", {edge_pol, edge_ena}, 48'h0);
    chk("R1 evt", edge_evt, 48'h0);
    bus_read(4'h7, rd);
    chk("R1 page/lock", rd, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) bus_write(VEC[i][19:16], VEC[i][15:8]);
      else begin
        bus_read(VEC[i][19:16], rd);
        chk($sformatf("R4 vector %0d", i), rd, VEC[i][7:0]);
      end
    end

    // R2 pin drive, R7 exports
    chk("R2 port0 sink", pin_sink[7:0], 8'h0F);
    chk("R2 port3 sink", pin_sink[31:24], 8'h3C);
    chk("R7 polarity out", edge_pol, 24'h332211);
    chk("R7 enable out", edge_ena, 24'h00F000);

    // R3 synchronizer latency and inversion
    @(negedge clk);
    ext_low[15:8] = 8'h81;
    bus_rd = 1'b1; bus_addr = 4'h1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R3 same-cycle read old", bus_rdata, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 8'h00);
    bus_read(4'h1, rd);
    chk("R3 inverted level", rd, 8'h81);
    ext_low = '0;

    // R9, R10 identity register
    bus_write(4'h7, 8'hC0);
    @(negedge clk); evt_set = 24'h010000;
    @(negedge clk); evt_set = '0;
    chk("R9 capture", edge_evt, 24'h010000);
    bus_read(4'hA, rd);
    chk("R9 byte2 read", rd, 8'h01);
    bus_read(4'h6, rd);
    chk("R10 pending", rd, 8'h04);
    bus_write(4'h9, 8'h80);
    chk("R7 identity write", edge_evt, 24'h018000);
    bus_read(4'h6, rd);
    chk("R10 pending two", rd, 8'h06);
    @(negedge clk); evt_clr = 1'b1; evt_set = 24'h000002;
    @(negedge clk); evt_clr = 1'b0; evt_set = '0;
    chk("R9 clear keeps new", edge_evt, 24'h000002);
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    chk("R9 clear", edge_evt, 24'h0);
    bus_read(4'h6, rd);
    chk("R10 pending clear", rd, 8'h00);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sink after reset", pin_sink, 48'h0);
    chk("R1 pol after reset", edge_pol, 48'h0);
    rst_n = 1'b1;
    bus_read(4'h7, rd);
    chk("R1 page after reset", rd, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule